// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words in the common single-precision layout: sign in bit 31, an 8-bit exponent with a bias of 127 in bits 30:23, and a 23-bit fraction in bits 22:0. A normal operand carries a hidden leading one, which gives 24 significant bits. The sign of the product is the exclusive-or of the operand signs. The biased exponents are added and one bias is removed. The two 24-bit significands are multiplied into a 48-bit product, which is normalised by a shift of at most one place.

The significand product comes from a hierarchical core. Each level splits both operands into halves, forms four half-width products and adds them with shifts. The split repeats until a small leaf width is reached. Exponent fields 0 and 255 are decoded as reserved values. An exponent of 0 means zero when the fraction is zero and a denormal otherwise; denormals are treated as zero. An exponent of 255 means infinity when the fraction is zero and NaN otherwise.

The result is truncated, not rounded. A result too large to represent saturates to infinity and raises an overflow flag. A result too small to represent flushes to signed zero and raises an underflow flag. The datapath is combinational, and an optional output register adds one cycle of latency.

Top module: `fpm_top`

## Requirements
- R1: For two normal operands, the result sign is the exclusive-or of the operand signs. The result exponent field is Ea + Eb − 127, plus 1 when the 48-bit significand product has bit 47 set.
- R2: The result fraction is truncated, not rounded. It is taken from product bits 46:24 when bit 47 is set, and from bits 45:23 otherwise.
- R3: When the result exponent computed under R1 is above 254, the result is infinity with the computed sign (exponent 255, fraction 0), `ovf` is 1 and `unf` is 0.
- R4: When the result exponent computed under R1 is below 1, the result is zero with the computed sign (all bits below bit 31 clear), `unf` is 1 and `ovf` is 0.
- R5: A zero operand (exponent 0, fraction 0) times a finite operand gives zero whose sign is the exclusive-or of the operand signs, with both flags 0.
- R6: A denormal operand (exponent 0, fraction nonzero) is treated as zero of the same sign.
- R7: If either operand is a NaN (exponent 255, fraction nonzero), the result is the quiet NaN 0x7FC00000 with both flags 0.
- R8: Zero or a denormal times infinity gives the quiet NaN 0x7FC00000 with both flags 0.
- R9: Infinity times a finite nonzero operand or times infinity gives infinity whose sign is the exclusive-or of the operand signs, with both flags 0.
- R10: With `OUT_REG` = 1, the outputs follow the inputs after one rising clock edge. A synchronous active-high `rst` clears `result`, `ovf` and `unf` to 0 at the next edge.
- R11: `ovf` and `unf` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 32 | First operand, single-precision |
| op_b | input | 32 | Second operand, single-precision |
| result | output | 32 | Product, single-precision, truncated |
| ovf | output | 1 | Result saturated to infinity |
| unf | output | 1 | Result flushed to zero |

## Verification
Hand-worked vectors set products at or above 2, which take the normalising shift, against products below 2, which do not; together they test the exponent increment and the choice of fraction window. An all-ones significand squared shows whether the fraction is truncated or rounded. Pairs placed exactly on the exponent limits 254/255 and 1/0 tell a correct saturation or flush from an off-by-one error. Each reserved encoding is paired with finite and infinite partners to test the precedence among NaN, zero times infinity, infinity and zero. A long run of random normal operands is compared with a reference model built on double-precision real arithmetic, which is exact for 48-bit products, then truncated and flushed.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int PROD_W = 2 * SIG_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 2;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [SIG_W-1:0]  sig;
    logic              zero;
    logic              inf;
    logic              nan;
  } opnd_t;
endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output opnd_t             info
);
  logic [EXP_W-1:0]  e_fld;
  logic [FRAC_W-1:0] f_fld;
  logic              e_low;
  logic              e_high;
  logic              f_any;

  assign e_fld  = word[FRAC_W +: EXP_W];
  assign f_fld  = word[FRAC_W-1:0];
  assign e_low  = (e_fld == '0);
  assign e_high = &e_fld;
  assign f_any  = |f_fld;

  always_comb begin
    info.sign = word[WORD_W-1];
    info.expo = e_fld;
    info.sig  = {~e_low, f_fld};
    info.zero = e_low;
    info.inf  = e_high & ~f_any;
    info.nan  = e_high & f_any;
  end
endmodule

// File: rtl/fpm_mant_core.sv
module fpm_mant_core #(
  parameter int W      = 24,
  parameter int LEAF_W = 6
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  generate
    if (W <= LEAF_W || (W % 2) != 0) begin : g_leaf
      assign p = a * b;
    end else begin : g_split
      localparam int H = W / 2;
      logic [2*H-1:0] p_ll, p_lh, p_hl, p_hh;
      logic [2*W-1:0] mid_a, mid_b;

      fpm_mant_core #(.W(H), .LEAF_W(LEAF_W)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
      fpm_mant_core #(.W(H), .LEAF_W(LEAF_W)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(p_lh));
      fpm_mant_core #(.W(H), .LEAF_W(LEAF_W)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(p_hl));
      fpm_mant_core #(.W(H), .LEAF_W(LEAF_W)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(p_hh));

      assign mid_a = {{(2*H){1'b0}}, p_lh} << H;
      assign mid_b = {{(2*H){1'b0}}, p_hl} << H;
      assign p     = {p_hh, p_ll} + mid_a + mid_b;
    end
  endgenerate
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack
  import fpm_pkg::*;
(
  input  opnd_t              a,
  input  opnd_t              b,
  input  logic [PROD_W-1:0]  prod,
  output logic [WORD_W-1:0]  word,
  output logic               ovf,
  output logic               unf
);
  localparam int EW2 = EXP_W + 2;
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic                     sgn;
  logic                     norm;
  logic [FRAC_W-1:0]        frac;
  logic signed [EW2-1:0]    esum;

  assign sgn  = a.sign ^ b.sign;
  assign norm = prod[PROD_W-1];
  assign frac = norm ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];
  assign esum = $signed({2'b00, a.expo}) + $signed({2'b00, b.expo})
              + $signed({{(EW2-1){1'b0}}, norm}) - $signed(EW2'(BIAS));

  always_comb begin
    word = '0;
    ovf  = 1'b0;
    unf  = 1'b0;
    if (a.nan || b.nan || (a.zero && b.inf) || (a.inf && b.zero)) begin
      word = QNAN;
    end else if (a.inf || b.inf) begin
      word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (a.zero || b.zero) begin
      word = {sgn, {(WORD_W-1){1'b0}}};
    end else if (esum > $signed(EW2'(EMAX))) begin
      word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf  = 1'b1;
    end else if (esum < $signed(EW2'(1))) begin
      word = {sgn, {(WORD_W-1){1'b0}}};
      unf  = 1'b1;
    end else begin
      word = {sgn, esum[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fpm_top.sv
module fpm_top
  import fpm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1,
  parameter int LEAF_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] result,
  output logic              ovf,
  output logic              unf
);
  opnd_t             cls_a, cls_b;
  logic [PROD_W-1:0] prod;
  logic [WORD_W-1:0] c_word;
  logic              c_ovf, c_unf;

  fpm_classify u_cls_a (.word(op_a), .info(cls_a));
  fpm_classify u_cls_b (.word(op_b), .info(cls_b));

  fpm_mant_core #(.W(SIG_W), .LEAF_W(LEAF_W)) u_core (
    .a(cls_a.sig), .b(cls_b.sig), .p(prod)
  );

  fpm_pack u_pack (
    .a(cls_a), .b(cls_b), .prod(prod),
    .word(c_word), .ovf(c_ovf), .unf(c_unf)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          result <= '0;
          ovf    <= 1'b0;
          unf    <= 1'b0;
        end else begin
          result <= c_word;
          ovf    <= c_ovf;
          unf    <= c_unf;
        end
      end

      // R10: a reset edge leaves all outputs cleared
      assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (result == '0 && !ovf && !unf));
    end else begin : g_comb
      assign result = c_word;
      assign ovf    = c_ovf;
      assign unf    = c_unf;
    end
  endgenerate

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(ovf && unf));

  assert_ovf_is_inf_R3: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  assert_unf_is_zero_R4: assert property (@(posedge clk) disable iff (rst)
    unf |-> (result[WORD_W-2:0] == '0));

  assert_nan_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ((&result[WORD_W-2:FRAC_W]) && (|result[FRAC_W-1:0])) |->
      (result == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}} && !ovf && !unf));
endmodule

// File: tb/sim_fpm_top.sv
module sim_fpm_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam int NRAND = 400;

  // Hand-worked vectors: operand a, operand b, expected word, expected {ovf,unf}
  localparam logic [31:0] VA [NV] = '{
    32'h40000000, 32'h41CA0000, 32'hBFC00000, 32'h3FFFFFFF,
    32'h00000000, 32'h80000000, 32'h00000001, 32'h7F800000,
    32'h7F800000, 32'h7F800001, 32'h00000001, 32'h7F000000,
    32'h7F000000, 32'h00800000, 32'h00800000, 32'hFF800000};
  localparam logic [31:0] VB [NV] = '{
    32'h40400000, 32'h3F800000, 32'h3FC00000, 32'h3FFFFFFF,
    32'h40A00000, 32'h40A00000, 32'hC0000000, 32'hC0000000,
    32'h00000000, 32'h3F800000, 32'h7F800000, 32'h40000000,
    32'h3F800000, 32'h3F000000, 32'h3F800000, 32'h7F800000};
  localparam logic [31:0] VY [NV] = '{
    32'h40C00000, 32'h41CA0000, 32'hC0100000, 32'h407FFFFE,
    32'h00000000, 32'h80000000, 32'h80000000, 32'hFF800000,
    32'h7FC00000, 32'h7FC00000, 32'h7FC00000, 32'h7F800000,
    32'h7F000000, 32'h00000000, 32'h00800000, 32'hFF800000};
  localparam logic [1:0] VF [NV] = '{
    2'b00, 2'b00, 2'b00, 2'b00,
    2'b00, 2'b00, 2'b00, 2'b00,
    2'b00, 2'b00, 2'b00, 2'b10,
    2'b00, 2'b01, 2'b00, 2'b00};
  localparam string VR [NV] = '{
    "R1", "R1", "R1", "R2", "R5", "R5", "R6", "R9",
    "R8", "R7", "R8", "R3", "R3", "R4", "R4", "R9"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] op_a = 32'h40000000;
  logic [31:0] op_b = 32'h40400000;
  logic [31:0] result;
  logic ovf, unf;
  int n_chk = 0;
  int n_err = 0;
  logic [31:0] rng = 32'h1234ABCD;

  fpm_top u0 (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
              .result(result), .ovf(ovf), .unf(unf));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] exp_y, input logic [1:0] exp_f);
    n_chk++;
    if (result !== exp_y || {ovf, unf} !== exp_f) begin
      n_err++;
      $display("FAIL %s: got %h flags %b, expected %h flags %b",
               req, result, {ovf, unf}, exp_y, exp_f);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Reference for normal operands: exact double product, then truncation and flush (R1-R4)
  function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] da, db, dp;
    logic [10:0] ea, eb;
    real ra, rb;
    int e;
    logic s;
    ea = {3'b000, a[30:23]} + 11'd896;
    eb = {3'b000, b[30:23]} + 11'd896;
    da = {a[31], ea, a[22:0], 29'd0};
    db = {b[31], eb, b[22:0], 29'd0};
    ra = $bitstoreal(da);
    rb = $bitstoreal(db);
    dp = $realtobits(ra * rb);
    e  = int'(dp[62:52]) - 896;
    s  = a[31] ^ b[31];
    if (e > 254) return {s, 8'hFF, 23'd0, 2'b10};
    if (e < 1)   return {s, 31'd0, 2'b01};
    return {s, e[7:0], dp[51:29], 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R10: reset state with live inputs
    repeat (2) @(negedge clk);
    check("R10 reset", 32'h0, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    check("R10 first edge", 32'h40C00000, 2'b00);

    // R10: output holds until the next rising edge
    op_a = 32'h3F800000;
    op_b = 32'h3F800000;
    #1;
    check("R10 hold", 32'h40C00000, 2'b00);
    @(negedge clk);
    check("R10 update", 32'h3F800000, 2'b00);

    for (int i = 0; i < NV; i++) begin
      apply(VA[i], VB[i]);
      check(VR[i], VY[i], VF[i]);
    end

    // R9: infinity times infinity; R5/R6: signed zero outcomes
    apply(32'hFF800000, 32'hFF800000);
    check("R9 inf*inf", 32'h7F800000, 2'b00);
    apply(32'h807FFFFF, 32'hC0000000);
    check("R6 neg denormal", 32'h00000000, 2'b00);
    apply(32'h3F800000, 32'h80000000);
    check("R5 finite*-0", 32'h80000000, 2'b00);
    apply(32'h7FFFFFFF, 32'h00000000);
    check("R7 nan*zero", 32'h7FC00000, 2'b00);

    // R1 R2 R3 R4: random normal operands against the reference
    for (int k = 0; k < NRAND; k++) begin
      logic [31:0] a, b;
      logic [33:0] r;
      rng = next_rng(rng);
      a = {rng[31], 8'(1 + (rng[30:23] % 254)), rng[22:0]};
      rng = next_rng(rng);
      b = {rng[31], 8'(1 + (rng[30:23] % 254)), rng[22:0]};
      r = ref_mul(a, b);
      apply(a, b);
      check("R1/R2 random", r[33:2], r[1:0]);
      if (ovf && unf) begin
        n_chk++;
        n_err++;
        $display("FAIL R11: got both flags, expected at most one");
      end
    end

    // R10: synchronous reset mid-run clears outputs
    apply(32'h7F000000, 32'h40000000);
    check("R3 pre-reset", 32'h7F800000, 2'b10);
    rst = 1'b1;
    #1;
    check("R10 sync reset waits", 32'h7F800000, 2'b10);
    @(negedge clk);
    check("R10 reset clears", 32'h0, 2'b00);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule